// File: doc/BRIEF.md
# Two-Phase Interleaved Cascaded First-Order Delta-Sigma Modulator

This block is the digital core of a high-rate delta-sigma DAC. Every clock it takes two 16-bit unsigned samples, an even-phase sample and an odd-phase sample, with the even sample earlier in time. It returns two 4-bit output codes per clock, one for each phase, so the logic runs at half the converted sample rate. A 2:1 multiplexer further down the chain, driven by the same clock, serialises the two codes. Each code is also given as 15 thermometer lines, which drive equally weighted unit elements.

The noise shaping comes from two first-order error-feedback stages in cascade, followed by noise-cancellation logic. Each stage's accumulator works by look-ahead: the even-phase and odd-phase updates are both computed from the state held at the start of the clock, so the odd update does not wait for the even result inside the loop. The carry of the second stage is differentiated across samples. This includes the step from one clock's odd phase to the next clock's even phase.

Top module: `mash_il2`

## Requirements
- R1: Each clock, `code_even` and `code_odd` equal the output of a serial single-rate cascaded first-order modulator that is fed the even sample and then the odd sample of that clock. Both codes appear at the outputs after the clock edge that samples the inputs.
- R2: Stage one splits each sample into a coarse part and a residue. The coarse part is bits 15:12 and goes straight to the output sum. The residue is bits 11:0 and is added into a 12-bit accumulator modulo 4096, and the overflow of that addition is the stage-one carry.
- R3: The odd-phase accumulator value equals the start-of-clock state plus the even residue plus the odd residue, modulo 4096. The odd carry is the overflow that a serial update would produce after the even update.
- R4: Stage two accumulates the updated stage-one value modulo 4096 in the same look-ahead form. Each code is coarse + c1 + c2[n] − c2[n−1]. The odd c2 of one clock serves as c2[n−1] for the next clock's even sample. Before saturation, a code lies within [coarse−1, coarse+2].
- R5: A code sum below 0 is output as 0, and a code sum above 15 is output as 15.
- R6: Thermometer line i of a phase (i = 0..14) is high exactly when that phase's code is greater than i.
- R7: A synchronous active-high reset sets both accumulators, the stored c2, both codes and all thermometer lines to zero. The first clock after reset is released already produces valid codes.
- R8: For a constant input x, the sum of the codes over 4096 consecutive samples from reset equals x or x+1 when no saturation occurs. The long-run mean is therefore x/4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the modulator and the downstream 2:1 multiplexer |
| rst | input | 1 | Synchronous active-high reset |
| din_even | input | 16 | Earlier sample of the pair, unsigned |
| din_odd | input | 16 | Later sample of the pair, unsigned |
| code_even | output | 4 | Registered output code, even phase |
| code_odd | output | 4 | Registered output code, odd phase |
| therm_even | output | 15 | Thermometer lines for the even code |
| therm_odd | output | 15 | Thermometer lines for the odd code |

## Verification
The hardest case is the carry hand-off between clocks. Here the odd-phase second-stage carry of one clock must cancel into the next clock's even code, and at the same moment the code sum leaves the range 0..15. The bench reaches this with long runs of a constant near-full input, which drives the sum to 16 or 17. It also uses a constant near-zero input, which makes a differenced carry produce −1. Every code is compared with a serial reference model, so a wrong hand-off or clamp shows up on the exact sample. Clocks whose even and odd samples differ bring out any difference between the look-ahead odd carry and the serial odd carry.

// File: rtl/mash_il_pkg.sv
package mash_il_pkg;

  localparam int unsigned DEF_IN_W   = 16;
  localparam int unsigned DEF_FRAC_W = 12;
  localparam int unsigned DEF_CODE_W = 4;

  // Limit an integer code sum to the representable range 0..hi
  function automatic int clamp_code(input int v, input int hi);
    if (v < 0)       return 0;
    else if (v > hi) return hi;
    else             return v;
  endfunction

endpackage

// File: rtl/mash_la_accum.sv
// Look-ahead error-feedback accumulator: both phase updates come from the
// state held at the start of the clock.
module mash_la_accum #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] add_e,
  input  logic [W-1:0] add_o,
  output logic         cy_e,
  output logic         cy_o,
  output logic [W-1:0] res_e,
  output logic [W-1:0] res_o
);

  logic [W-1:0] st_q;
  logic [W:0]   sum_e;
  logic [W+1:0] sum_o;

  always_comb begin
    sum_e = {1'b0, st_q} + {1'b0, add_e};
    sum_o = {2'b00, st_q} + {2'b00, add_e} + {2'b00, add_o};
    res_e = sum_e[W-1:0];
    res_o = sum_o[W-1:0];
    cy_e  = sum_e[W];
    // total overflow count is cy_e + cy_o (0..2); recover the odd share
    cy_o  = sum_o[W] ^ sum_e[W];
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= res_o;
  end

endmodule

// File: rtl/mash_cancel.sv
// Noise cancellation: coarse + c1 + c2[n] - c2[n-1], clamped.
module mash_cancel
  import mash_il_pkg::*;
#(
  parameter int unsigned MSB_W  = 4,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MSB_W-1:0]  msb_e,
  input  logic [MSB_W-1:0]  msb_o,
  input  logic              c1_e,
  input  logic              c1_o,
  input  logic              c2_e,
  input  logic              c2_o,
  output logic [CODE_W-1:0] y_e,
  output logic [CODE_W-1:0] y_o
);

  localparam int CODE_MAX = (2 ** CODE_W) - 1;

  logic c2_last_q;
  int   raw_e, raw_o;

  always_comb begin
    raw_e = int'(msb_e) + int'(c1_e) + int'(c2_e) - int'(c2_last_q);
    raw_o = int'(msb_o) + int'(c1_o) + int'(c2_o) - int'(c2_e);
    y_e   = CODE_W'(clamp_code(raw_e, CODE_MAX));
    y_o   = CODE_W'(clamp_code(raw_o, CODE_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) c2_last_q <= 1'b0;
    else     c2_last_q <= c2_o;
  end

endmodule

// File: rtl/mash_therm.sv
module mash_therm #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned LINES  = (2 ** CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  lines
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (code > CODE_W'(i));
  end

endmodule

// File: rtl/mash_il2.sv
module mash_il2
  import mash_il_pkg::*;
#(
  parameter int unsigned IN_W   = DEF_IN_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned CODE_W = DEF_CODE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IN_W-1:0]          din_even,
  input  logic [IN_W-1:0]          din_odd,
  output logic [CODE_W-1:0]        code_even,
  output logic [CODE_W-1:0]        code_odd,
  output logic [(2**CODE_W)-2:0]   therm_even,
  output logic [(2**CODE_W)-2:0]   therm_odd
);

  localparam int unsigned MSB_W = IN_W - FRAC_W;
  localparam int unsigned LINES = (2 ** CODE_W) - 1;
  localparam int unsigned NPH   = 2;

  logic              c1_e, c1_o, c2_e, c2_o;
  logic [FRAC_W-1:0] e1_e, e1_o;
  logic [FRAC_W-1:0] s2_res_e_unused, s2_res_o_unused;

  logic [NPH-1:0][CODE_W-1:0] code_nx;
  logic [NPH-1:0][LINES-1:0]  therm_nx;
  logic [NPH-1:0][CODE_W-1:0] code_q;
  logic [NPH-1:0][LINES-1:0]  therm_q;

  mash_la_accum #(.W(FRAC_W)) u_stage1 (
    .clk   (clk),
    .rst   (rst),
    .add_e (din_even[FRAC_W-1:0]),
    .add_o (din_odd[FRAC_W-1:0]),
    .cy_e  (c1_e),
    .cy_o  (c1_o),
    .res_e (e1_e),
    .res_o (e1_o)
  );

  mash_la_accum #(.W(FRAC_W)) u_stage2 (
    .clk   (clk),
    .rst   (rst),
    .add_e (e1_e),
    .add_o (e1_o),
    .cy_e  (c2_e),
    .cy_o  (c2_o),
    .res_e (s2_res_e_unused),
    .res_o (s2_res_o_unused)
  );

  mash_cancel #(.MSB_W(MSB_W), .CODE_W(CODE_W)) u_cancel (
    .clk   (clk),
    .rst   (rst),
    .msb_e (din_even[IN_W-1 -: MSB_W]),
    .msb_o (din_odd[IN_W-1 -: MSB_W]),
    .c1_e  (c1_e),
    .c1_o  (c1_o),
    .c2_e  (c2_e),
    .c2_o  (c2_o),
    .y_e   (code_nx[0]),
    .y_o   (code_nx[1])
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    mash_therm #(.CODE_W(CODE_W), .LINES(LINES)) u_therm (
      .code  (code_nx[p]),
      .lines (therm_nx[p])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q[p]  <= '0;
        therm_q[p] <= '0;
      end else begin
        code_q[p]  <= code_nx[p];
        therm_q[p] <= therm_nx[p];
      end
    end
  end

  assign code_even  = code_q[0];
  assign code_odd   = code_q[1];
  assign therm_even = therm_q[0];
  assign therm_odd  = therm_q[1];

endmodule

// File: rtl/mash_il2_chk.sv
module mash_il2_chk #(
  parameter int unsigned MSB_W  = 4,
  parameter int unsigned CODE_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [MSB_W-1:0]       msb_even,
  input logic [MSB_W-1:0]       msb_odd,
  input logic [CODE_W-1:0]      code_even,
  input logic [CODE_W-1:0]      code_odd,
  input logic [(2**CODE_W)-2:0] therm_even,
  input logic [(2**CODE_W)-2:0] therm_odd
);

  logic             armed;
  logic [MSB_W-1:0] msb_e_q, msb_o_q;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
    msb_e_q <= msb_even;
    msb_o_q <= msb_odd;
  end

  // R6
  therm_even_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(therm_even) == int'(code_even));

  // R6
  therm_odd_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(therm_odd) == int'(code_odd));

  // R4
  even_window_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (int'(code_even) + 1 >= int'(msb_e_q)) &&
              (int'(code_even) <= int'(msb_e_q) + 2));

  // R4
  odd_window_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (int'(code_odd) + 1 >= int'(msb_o_q)) &&
              (int'(code_odd) <= int'(msb_o_q) + 2));

endmodule

bind mash_il2 mash_il2_chk #(
  .MSB_W  (IN_W - FRAC_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .msb_even   (din_even[IN_W-1 -: (IN_W - FRAC_W)]),
  .msb_odd    (din_odd[IN_W-1 -: (IN_W - FRAC_W)]),
  .code_even  (code_even),
  .code_odd   (code_odd),
  .therm_even (therm_even),
  .therm_odd  (therm_odd)
);

// File: tb/tb_mash_il2.sv
module tb_mash_il2;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din_even = '0;
  logic [15:0] din_odd  = '0;
  logic [3:0]  code_even, code_odd;
  logic [14:0] therm_even, therm_odd;

  int n_chk  = 0;
  int n_fail = 0;

  // serial reference state
  int r_s1 = 0, r_s2 = 0, r_c2p = 0;
  int code_sum = 0;
  int sat_hits = 0;

  always #(CLK_P/2) clk = ~clk;

  mash_il2 dut (
    .clk        (clk),
    .rst        (rst),
    .din_even   (din_even),
    .din_odd    (din_odd),
    .code_even  (code_even),
    .code_odd   (code_odd),
    .therm_even (therm_even),
    .therm_odd  (therm_odd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void ref_clear();
    r_s1 = 0; r_s2 = 0; r_c2p = 0;
  endfunction

  // one sample of a plain single-rate cascade
  function automatic int ref_step(input int x);
    int t, c1, c2, y;
    t    = r_s1 + (x & 4095);
    c1   = t >> 12;
    r_s1 = t & 4095;
    t    = r_s2 + r_s1;
    c2   = t >> 12;
    r_s2 = t & 4095;
    y    = (x >> 12) + c1 + c2 - r_c2p;
    r_c2p = c2;
    if (y > 15 || y < 0) sat_hits++;
    if (y < 0)  y = 0;
    if (y > 15) y = 15;
    return y;
  endfunction

  task automatic run_pair(input int xe, input int xo, input string tag);
    int ye, yo;
    din_even = xe[15:0];
    din_odd  = xo[15:0];
    ye = ref_step(xe);
    yo = ref_step(xo);
    @(posedge clk); #1;
    chk({tag, " even"}, int'(code_even), ye);
    chk({tag, " odd"},  int'(code_odd),  yo);
    chk("R6 even lines", int'(therm_even), (1 << int'(code_even)) - 1);
    chk("R6 odd lines",  int'(therm_odd),  (1 << int'(code_odd)) - 1);
    code_sum += int'(code_even) + int'(code_odd);
  endtask

  task automatic apply_reset();
    din_even = 16'hFFFF;
    din_odd  = 16'hFFFF;
    rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R7 reset code_even", int'(code_even), 0);
    chk("R7 reset code_odd",  int'(code_odd), 0);
    chk("R7 reset therm_even", int'(therm_even), 0);
    chk("R7 reset therm_odd",  int'(therm_odd), 0);
    rst = 1'b0;
    ref_clear();
    code_sum = 0;
  endtask

  task automatic t_reset();
    apply_reset();
    run_pair(16'h8123, 16'h8123, "R7 first clock");
  endtask

  task automatic t_const_mean();
    int x;
    x = 16'h5A3C;
    apply_reset();
    for (int k = 0; k < 2048; k++) run_pair(x, x, "R1 R2 const");
    n_chk++;
    if (code_sum != x && code_sum != x + 1) begin
      n_fail++;
      $display("FAIL R8 mean: actual %0d expected %0d or %0d", code_sum, x, x + 1);
    end
  endtask

  task automatic t_split_phase();
    apply_reset();
    for (int k = 0; k < 600; k++)
      run_pair((16'h3000 + k * 37) & 16'hFFFF, (16'h7FFF - k * 53) & 16'hFFFF,
               "R3 R4 split");
  endtask

  task automatic t_saturate();
    apply_reset();
    sat_hits = 0;
    for (int k = 0; k < 300; k++) run_pair(16'hFFFF, 16'hFFF0, "R5 high");
    n_chk++;
    if (sat_hits == 0) begin
      n_fail++;
      $display("FAIL R5 high clamp not reached: actual %0d expected >0", sat_hits);
    end
    apply_reset();
    sat_hits = 0;
    for (int k = 0; k < 300; k++) run_pair(16'h0003, 16'h0005, "R5 low");
    n_chk++;
    if (sat_hits == 0) begin
      n_fail++;
      $display("FAIL R5 low clamp not reached: actual %0d expected >0", sat_hits);
    end
  endtask

  task automatic t_mid_reset();
    apply_reset();
    for (int k = 0; k < 40; k++) run_pair(16'h9ABC, 16'h1357, "R4 pre");
    apply_reset();
    for (int k = 0; k < 60; k++) run_pair(16'h2468, 16'hC0DE, "R7 restart");
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_const_mean();
    t_split_phase();
    t_saturate();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule